// File: doc/BRIEF.md
# Radio Operating Mode Sequencer

This block sits next to the serial register file of a multi-channel radio transceiver and turns register writes into the power-enable lines of the analog subsystems. A 3-bit operating-mode field, held in main register 0, is decoded into separate enables for the crystal-oscillator output, PLL, VCO, LO generation, LNA, receive chain, receive baseband buffers, transmit chain, transmit lowpass-filter bypass, AM detector and baseband loopback path. The same register also carries a bank-select bit. When it is set, writes to addresses 1 to 31 go to a local bank and are not seen as main-register writes.

In transmit mode the external power-amplifier bias output follows the transmit enable after a programmable number of ticks, so the power amplifier turns on only once the transmit chain has settled. The block also times VCO sub-band acquisition. Writing main registers 15, 16 and 17 back to back starts a busy window that lasts a parameterised number of ticks, which covers the 2 ms acquisition. A lock-done flag reports that the window has ended. All timing counts `tick` pulses, which are single-cycle enables in the `clk` domain.

Top module: `radio_mode_seq`

## Requirements
- R1: After reset the mode field is 000 and the bank bit is 0. Only `xo_en` is high, and `pa_bias`, `acq_busy` and `lock_done` are low.
- R2: A write to address 0 stores `wr_data[4:2]` as the mode and `wr_data[0]` as the bank bit. The enables take the new mode on the clock edge that captures the write. Address 0 is always a main-bank register.
- R3: Mode 000 (clock-out) drives only `xo_en`. Mode 001 (standby) and the unused code 111 drive `xo_en`, `pll_en`, `vco_en` and `lo_en`, and nothing else.
- R4: Mode 010 (receive) drives the standby set plus `lna_en`, `rx_en` and `rx_buf_en`. Mode 011 (transmit) drives the standby set plus `tx_en`.
- R5: Mode 100 (transmit calibration) drives the standby set plus `tx_en`, `amdet_en` and `rx_buf_en`. Mode 101 (RF loopback) drives the standby set plus `tx_en`, `rx_en`, `rx_buf_en` and `tx_lpf_byp`, with `lna_en` low. Mode 110 (baseband loopback) drives the standby set plus `tx_en`, `rx_en`, `rx_buf_en` and `bb_loop_en`.
- R6: Main register 6, bits 7:0, holds the PA delay D. On the edge that enters transmit from any other mode, the delay counter loads D. It then counts down one per tick while transmit is held. `pa_bias` is high exactly when the mode is transmit and the counter is zero, so D = 0 raises it together with `tx_en`. Leaving transmit drops it at once. Rewriting mode 011 while already in transmit does not reload the counter.
- R7: Three consecutive writes to main registers 15, 16 and 17, in that order, raise `acq_busy` on the edge that captures the third write. `acq_busy` falls after exactly ACQ_TICKS ticks. A tick on the start edge is not counted.
- R8: Any write that is not the expected next step resets the sequence tracker. This includes a write to address 0, to the local bank, or to the wrong address. A main write to register 15 always counts as the first step.
- R9: `lock_done` rises on the edge where `acq_busy` falls and is cleared when a new acquisition starts. `lock_done` and `acq_busy` are never high together.
- R10: A complete 15, 16, 17 sequence during an acquisition reloads the window to ACQ_TICKS ticks.
- R11: While the bank bit is 1, writes to addresses 1 to 31 update no main register. They do not change the PA delay and they do not advance the acquisition sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle timing enable for the delay and acquisition counters |
| wr_en | input | 1 | Register-write strobe |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 10 | Register data of the write |
| xo_en | output | 1 | Crystal-oscillator output enable |
| pll_en | output | 1 | PLL enable |
| vco_en | output | 1 | VCO enable |
| lo_en | output | 1 | LO-generation enable |
| lna_en | output | 1 | LNA enable |
| rx_en | output | 1 | Receive downconverter and filter enable |
| rx_buf_en | output | 1 | Receive baseband buffer enable |
| tx_en | output | 1 | Transmit chain enable |
| tx_lpf_byp | output | 1 | Transmit lowpass-filter bypass |
| amdet_en | output | 1 | AM detector enable |
| bb_loop_en | output | 1 | Baseband loopback path enable |
| pa_bias | output | 1 | External power-amplifier bias enable |
| acq_busy | output | 1 | VCO acquisition window in progress |
| lock_done | output | 1 | Acquisition window has completed |

## Verification
The hardest case to reach is an acquisition started from a sequence broken in the middle and then restarted. This covers a stray write between steps, a repeated 15, a write from the local bank, and a full sequence arriving while a window is already counting. The stimulus issues these write orders one after another and uses a tick pattern that skips every third cycle, so start edges and tick edges fall both together and apart. A reference model derived from the requirements predicts every output on every cycle. The same run also enters transmit with a zero and a non-zero PA delay, and rewrites transmit while in transmit, to show that the delay counter does not reload.

// File: rtl/radio_mode_seq.sv
module radio_mode_seq #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 10,
  parameter int MODE_LSB  = 2,
  parameter int PA_DLY_W  = 8,
  parameter int ACQ_TICKS = 2000,
  parameter int MODE_ADDR = 0,
  parameter int PA_ADDR   = 6,
  parameter int ACQ_ADDR0 = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              xo_en,
  output logic              pll_en,
  output logic              vco_en,
  output logic              lo_en,
  output logic              lna_en,
  output logic              rx_en,
  output logic              rx_buf_en,
  output logic              tx_en,
  output logic              tx_lpf_byp,
  output logic              amdet_en,
  output logic              bb_loop_en,
  output logic              pa_bias,
  output logic              acq_busy,
  output logic              lock_done
);

  localparam int ACQ_W = $clog2(ACQ_TICKS + 1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] A_PA   = ADDR_W'(PA_ADDR);
  localparam logic [ADDR_W-1:0] A_S0   = ADDR_W'(ACQ_ADDR0);
  localparam logic [ADDR_W-1:0] A_S1   = ADDR_W'(ACQ_ADDR0 + 1);
  localparam logic [ADDR_W-1:0] A_S2   = ADDR_W'(ACQ_ADDR0 + 2);

  localparam logic [2:0] M_CLKOUT = 3'b000;
  localparam logic [2:0] M_STBY   = 3'b001;
  localparam logic [2:0] M_RX     = 3'b010;
  localparam logic [2:0] M_TX     = 3'b011;
  localparam logic [2:0] M_CAL    = 3'b100;
  localparam logic [2:0] M_RFLB   = 3'b101;
  localparam logic [2:0] M_BBLB   = 3'b110;

  logic [2:0]          mode_q;
  logic                bank_q;
  logic [PA_DLY_W-1:0] pa_dly_q, pa_cnt_q;
  logic [1:0]          seq_q;
  logic [ACQ_W-1:0]    acq_cnt_q;
  logic                busy_q, lock_q;
  logic [10:0]         en;

  wire [2:0] new_mode = wr_data[MODE_LSB+2:MODE_LSB];
  wire mode_wr  = wr_en && (wr_addr == A_MODE);
  wire main_wr  = wr_en && (mode_wr || !bank_q);
  wire is_tx    = (mode_q == M_TX);
  wire enter_tx = mode_wr && (new_mode == M_TX) && !is_tx;
  wire acq_go   = main_wr && (seq_q == 2'd2) && (wr_addr == A_S2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= M_CLKOUT;
      bank_q <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= new_mode;
      bank_q <= wr_data[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      pa_dly_q <= '0;
    else if (main_wr && wr_addr == A_PA)
      pa_dly_q <= wr_data[PA_DLY_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      pa_cnt_q <= '0;
    else if (enter_tx)
      pa_cnt_q <= pa_dly_q;
    else if (is_tx && tick && pa_cnt_q != '0)
      pa_cnt_q <= pa_cnt_q - 1'b1;

  assign pa_bias = is_tx && (pa_cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      seq_q <= 2'd0;
    else if (wr_en) begin
      if (main_wr && wr_addr == A_S0)                      seq_q <= 2'd1;
      else if (main_wr && seq_q == 2'd1 && wr_addr == A_S1) seq_q <= 2'd2;
      else                                                  seq_q <= 2'd0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q    <= 1'b0;
      lock_q    <= 1'b0;
      acq_cnt_q <= '0;
    end else if (acq_go) begin
      busy_q    <= 1'b1;
      lock_q    <= 1'b0;
      acq_cnt_q <= ACQ_W'(ACQ_TICKS);
    end else if (busy_q && tick) begin
      acq_cnt_q <= acq_cnt_q - 1'b1;
      if (acq_cnt_q == ACQ_W'(1)) begin
        busy_q <= 1'b0;
        lock_q <= 1'b1;
      end
    end

  assign acq_busy  = busy_q;
  assign lock_done = lock_q;

  // order: xo pll vco lo lna rx rxbuf tx txbyp amdet bbloop
  always_comb begin
    case (mode_q)
      M_CLKOUT: en = 11'b1000_0000_000;
      M_RX:     en = 11'b1111_1110_000;
      M_TX:     en = 11'b1111_0001_000;
      M_CAL:    en = 11'b1111_0011_010;
      M_RFLB:   en = 11'b1111_0111_100;
      M_BBLB:   en = 11'b1111_0111_001;
      default:  en = 11'b1111_0000_000;
    endcase
  end

  assign {xo_en, pll_en, vco_en, lo_en, lna_en, rx_en, rx_buf_en,
          tx_en, tx_lpf_byp, amdet_en, bb_loop_en} = en;

  p_pa_needs_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pa_bias |-> tx_en);
  p_pa_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pa_bias) |-> ($past(tick) || $past(mode_wr)));
  p_lna_needs_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lna_en |-> (rx_en && rx_buf_en && pll_en));
  p_busy_lock_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_busy && lock_done));
  p_lock_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_done) |-> $fell(acq_busy));
  p_start_on_last_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_busy) |-> $past(wr_en && wr_addr == A_S2));
  p_busy_count_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acq_busy |-> (acq_cnt_q != '0));
  p_bank_blocks_pa_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && bank_q && wr_addr != A_MODE)) |-> $stable(pa_dly_q));

endmodule

// File: tb/radio_mode_seq_tb.sv
module radio_mode_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACQ = 24;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic xo_en, pll_en, vco_en, lo_en, lna_en, rx_en, rx_buf_en, tx_en,
        tx_lpf_byp, amdet_en, bb_loop_en, pa_bias, acq_busy, lock_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_mode_seq #(.ACQ_TICKS(ACQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xo_en(xo_en), .pll_en(pll_en), .vco_en(vco_en),
    .lo_en(lo_en), .lna_en(lna_en), .rx_en(rx_en), .rx_buf_en(rx_buf_en),
    .tx_en(tx_en), .tx_lpf_byp(tx_lpf_byp), .amdet_en(amdet_en),
    .bb_loop_en(bb_loop_en), .pa_bias(pa_bias), .acq_busy(acq_busy),
    .lock_done(lock_done));

  typedef struct packed {
    logic [10:0] en;
    logic pa, busy, lock;
    logic [31:0] tag;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  logic [31:0] phase = "R1";
  bit done = 0;

  function automatic logic [10:0] en_for(logic [2:0] m);
    case (m)
      3'b000: return 11'b1000_0000_000;
      3'b010: return 11'b1111_1110_000;
      3'b011: return 11'b1111_0001_000;
      3'b100: return 11'b1111_0011_010;
      3'b101: return 11'b1111_0111_100;
      3'b110: return 11'b1111_0111_001;
      default: return 11'b1111_0000_000;
    endcase
  endfunction

  logic [2:0] m_mode; logic m_bank, m_busy, m_lock;
  logic [7:0] m_pad, m_pacnt; logic [1:0] m_seq; int m_cnt;
  bit m_main, m_start, m_enter;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_bank = 0; m_pad = 0; m_pacnt = 0; m_seq = 0;
      m_busy = 0; m_lock = 0; m_cnt = 0;
    end else begin
      m_enter = wr_en && wr_addr == 0 && wr_data[4:2] == 3'b011 && m_mode != 3'b011;
      m_main  = wr_en && (wr_addr == 0 || !m_bank);
      if (m_enter) m_pacnt = m_pad;
      else if (m_mode == 3'b011 && tick && m_pacnt != 0) m_pacnt = m_pacnt - 1;
      m_start = 0;
      if (wr_en) begin
        if (m_main && wr_addr == 15) m_seq = 1;
        else if (m_main && m_seq == 1 && wr_addr == 16) m_seq = 2;
        else if (m_main && m_seq == 2 && wr_addr == 17) begin m_start = 1; m_seq = 0; end
        else m_seq = 0;
      end
      if (m_start) begin m_busy = 1; m_lock = 0; m_cnt = ACQ; end
      else if (m_busy && tick) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin m_busy = 0; m_lock = 1; end
      end
      if (m_main && wr_addr == 6) m_pad = wr_data[7:0];
      if (wr_en && wr_addr == 0) begin m_mode = wr_data[4:2]; m_bank = wr_data[0]; end
    end
    q.push_back('{en: en_for(m_mode), pa: (m_mode == 3'b011 && m_pacnt == 0),
                  busy: m_busy, lock: m_lock, tag: phase});
  end

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      logic [10:0] act;
      e = q.pop_front();
      act = {xo_en, pll_en, vco_en, lo_en, lna_en, rx_en, rx_buf_en,
             tx_en, tx_lpf_byp, amdet_en, bb_loop_en};
      compared++;
      if (act !== e.en || pa_bias !== e.pa || acq_busy !== e.busy || lock_done !== e.lock) begin
        mismatched++;
        $display("FAIL %s at %0t: en=%b pa=%b busy=%b lock=%b expected en=%b pa=%b busy=%b lock=%b",
                 e.tag, $time, act, pa_bias, acq_busy, lock_done, e.en, e.pa, e.busy, e.lock);
      end
    end
  end

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    tick <= (tdiv != 0);
  end

  task automatic wr(input logic [4:0] a, input logic [9:0] d);
    @(negedge clk); wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
    @(negedge clk); wr_en <= 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m, input logic bank);
    wr(5'd0, {5'b0, m, 1'b0, bank});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seq3();
    @(negedge clk); wr_en <= 1'b1; wr_addr <= 5'd15; wr_data <= 10'h0;
    @(negedge clk); wr_addr <= 5'd16;
    @(negedge clk); wr_addr <= 5'd17;
    @(negedge clk); wr_en <= 1'b0;
  endtask

  task automatic finish_run();
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    phase = "R1"; idle(4); rst_n = 1'b1; idle(3);
    phase = "R3"; set_mode(3'b000, 0); idle(2); set_mode(3'b001, 0); idle(2);
    set_mode(3'b111, 0); idle(2);
    phase = "R2"; wr(5'd0, 10'b1110_0100_10); idle(2);
    phase = "R4"; set_mode(3'b010, 0); idle(3); set_mode(3'b011, 0); idle(3);
    phase = "R5"; set_mode(3'b100, 0); idle(2); set_mode(3'b101, 0); idle(2);
    set_mode(3'b110, 0); idle(2);
    phase = "R6"; wr(5'd6, 10'd5); set_mode(3'b011, 0); idle(12);
    set_mode(3'b011, 0); idle(4); set_mode(3'b001, 0); idle(2);
    set_mode(3'b011, 0); idle(3); set_mode(3'b010, 0);
    wr(5'd6, 10'd0); set_mode(3'b011, 0); idle(2); set_mode(3'b001, 0); idle(2);
    phase = "R7"; seq3(); idle(ACQ * 2);
    phase = "R9"; idle(3); seq3(); idle(4);
    phase = "R10"; seq3(); idle(ACQ * 2);
    phase = "R8";
    wr(5'd15, 0); wr(5'd17, 0); idle(2);
    wr(5'd15, 0); wr(5'd16, 0); wr(5'd5, 0); wr(5'd17, 0); idle(2);
    wr(5'd15, 0); wr(5'd16, 0); set_mode(3'b001, 0); wr(5'd17, 0); idle(2);
    wr(5'd16, 0); wr(5'd15, 0); wr(5'd15, 0); wr(5'd16, 0); wr(5'd17, 0);
    idle(ACQ * 2);
    phase = "R11"; set_mode(3'b001, 1); seq3(); idle(4);
    wr(5'd6, 10'd4); set_mode(3'b011, 1); idle(6); set_mode(3'b001, 0);
    wr(5'd15, 0); set_mode(3'b001, 1); wr(5'd16, 0); set_mode(3'b001, 0);
    wr(5'd17, 0); idle(4);
    wr(5'd6, 10'd4); set_mode(3'b011, 0); idle(10); set_mode(3'b000, 0); idle(3);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog: run still active, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule